// File: doc/BRIEF.md
# Paged Serial Flash Read Window

This block lets a CPU with a 24-bit address bus read the upper part of its address space straight out of a serial NOR flash. The flash region starts at `0x00C000` and runs to the top of the address space. Only that region is decoded to this block. A CPU address selects the flash byte with the same offset, so flash bytes below `0x00C000` are never seen.

One page of flash (4096 bytes by default) is held in an on-chip buffer, and the block remembers which page that is. A read inside the held page is served at once. A read anywhere else raises `stall`, fetches the whole new page over a mode-0 SPI link with a plain read command, and then finishes the read from the buffer. The old page is dropped and never written back.

CPU writes into the region are accepted without a stall and change nothing. The CPU keeps `req`, `we` and `addr` steady for as long as `stall` is high. A read is taken on the first rising clock edge where `req` is high, `we` is low and `stall` is low. The byte appears on `rdata` after that edge.

Top module: `flash_page_window`

## Requirements
- R1: A read whose page is the valid held page gives `stall` low in the same cycle. `rdata` then carries the flash byte at that address after the next rising clock edge.
- R2: A read outside the held page holds `stall` high for at least 2·(32 + 8·PAGE) clock cycles, because each SCK period takes two clocks. The read then completes with the correct flash byte.
- R3: Each page fill lowers `spi_cs_n` and sends 32 bits MSB first: command byte `0x03` and then the 24-bit page base address, whose low PAGE_BITS bits are zero. The link uses SPI mode 0: SCK idles low, MOSI changes on the falling edge, and the flash samples on the rising edge.
- R4: After the 32 header bits, a fill clocks exactly 8·PAGE data bits. It then raises `spi_cs_n`.
- R5: `spi_cs_n` stays high for at least two clock cycles (one SCK period) before each fill. `spi_sck` is low whenever `spi_cs_n` is high.
- R6: After reset no page is valid. The first read misses, including a read in the page that the reset tag value names (the page at `0x00C000`).
- R7: A write (`req` and `we` high) never raises `stall`, starts no SPI transfer and leaves the buffered data unchanged.
- R8: Only one page is held at a time. After a fill of a new page, a read of the page held before it misses again and is fetched again.
- R9: While reset is active and right after it, `stall` is low with no request, `spi_cs_n` is high and `spi_sck` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | CPU access to the flash region |
| we | input | 1 | Access is a write (ignored) |
| addr | input | ADDR_W | CPU byte address |
| rdata | output | 8 | Read data, valid after the completing edge |
| stall | output | 1 | Hold the CPU; the access has not completed |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The assertions rely on two input conditions. The CPU keeps `req`, `we` and `addr` unchanged while `stall` is high, and it only presents addresses at or above `0x00C000`. The flash model drives MISO only after a falling SCK edge while chip select is low. The bench drives every access from a task that holds the request until the stall drops. It draws addresses from four fixed page bases, including the region base and the top page, plus a random offset. Writes are mixed in at random. The page size is reduced for simulation so that many fills fit in the run.

// File: rtl/flash_page_window.sv
module flash_page_window #(
  parameter int ADDR_W = 24,
  parameter int PAGE_BITS = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'h00C000,
  parameter logic [7:0] RD_CMD = 8'h03,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        rdata,
  output logic              stall,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int PAGE = 1 << PAGE_BITS;
  localparam int TW   = ADDR_W - PAGE_BITS;
  localparam int HW   = 8 + ADDR_W;
  localparam int CW   = (PAGE_BITS + 3 > $clog2(HW)) ? PAGE_BITS + 3 : $clog2(HW);
  localparam int GW   = $clog2(GAP_CYC + 1);
  localparam logic [TW-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:PAGE_BITS];

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_CMD, S_DATA} state_t;

  state_t         state;
  logic           valid, ph;
  logic [TW-1:0]  tag, fill_tag;
  logic [CW-1:0]  cnt;
  logic [GW-1:0]  gcnt;
  logic [HW-1:0]  sh;
  logic [6:0]     rx;
  logic [7:0]     mem [PAGE];

  wire rd  = req && !we;
  wire hit = valid && (tag == addr[ADDR_W-1:PAGE_BITS]);

  assign stall    = rd && (state != S_IDLE || !hit);
  assign spi_cs_n = !(state == S_CMD || state == S_DATA);
  assign spi_sck  = ph;
  assign spi_mosi = sh[HW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      valid    <= 1'b0;
      tag      <= BASE_TAG;
      fill_tag <= BASE_TAG;
      gcnt     <= '0;
      cnt      <= '0;
      ph       <= 1'b0;
      sh       <= '0;
      rx       <= '0;
    end else begin
      case (state)
        S_IDLE: if (rd && !hit) begin
          state    <= S_GAP;
          valid    <= 1'b0;
          fill_tag <= addr[ADDR_W-1:PAGE_BITS];
          gcnt     <= '0;
        end
        S_GAP: begin
          gcnt <= gcnt + 1'b1;
          if (gcnt == GW'(GAP_CYC - 1)) begin
            state <= S_CMD;
            sh    <= {RD_CMD, fill_tag, {PAGE_BITS{1'b0}}};
            cnt   <= '0;
            ph    <= 1'b0;
          end
        end
        S_CMD: begin
          ph <= ~ph;
          if (ph) begin
            sh  <= sh << 1;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(HW - 1)) begin
              state <= S_DATA;
              cnt   <= '0;
            end
          end
        end
        S_DATA: begin
          ph <= ~ph;
          if (ph) begin
            rx  <= {rx[5:0], spi_miso};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(8 * PAGE - 1)) begin
              state <= S_IDLE;
              valid <= 1'b1;
              tag   <= fill_tag;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_DATA && ph && cnt[2:0] == 3'd7)
      mem[cnt[PAGE_BITS+2:3]] <= {rx, spi_miso};
    if (rd && !stall)
      rdata <= mem[addr[PAGE_BITS-1:0]];
  end

  p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  p_cs_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(spi_cs_n, 2));

  p_write_nostall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we) |-> !stall);

  p_fill_end_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (valid && state == S_IDLE));

  p_read_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !stall) |-> (spi_cs_n && valid));

  p_reset_cs_r9: assert property (@(posedge clk)
    !rst_n |=> (spi_cs_n && !spi_sck));
endmodule

// File: tb/test_flash_page_window.sv
`timescale 1ns/1ps
module test_flash_page_window;
  localparam int PB   = 6;
  localparam int PAGE = 1 << PB;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [23:0] addr = 24'h00C000;
  logic [7:0]  rdata;
  logic        stall, spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int tests = 0, fails = 0, fills = 0, nrise = 0, hi_cnt = 0;
  logic [31:0] hdr = '0;
  logic [23:0] exp_base = '0;
  bit          have_page = 0;
  logic [23:0] cur_page = '0;

  flash_page_window #(.ADDR_W(24), .PAGE_BITS(PB)) i_flash_page_window (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .rdata(rdata),
    .stall(stall), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso));

  always #2 clk = ~clk;

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ (a[23:16] * 8'd3) ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // flash model, SPI mode 0
  always @(negedge spi_cs_n) begin
    nrise = 0;
    chk(hi_cnt >= 2, "R5 cs high gap", hi_cnt, 2);
  end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    if (nrise < 32) hdr = {hdr[30:0], spi_mosi};
    nrise++;
  end
  always @(negedge spi_sck) if (!spi_cs_n && nrise >= 32) begin
    automatic int idx = nrise - 32;
    automatic logic [7:0] b = fbyte(hdr[23:0] + 24'(idx / 8));
    spi_miso = b[7 - idx % 8];
  end
  always @(posedge spi_cs_n) if (rst_n) begin
    fills++;
    chk(nrise == 32 + 8 * PAGE, "R4 bit count", nrise, 32 + 8 * PAGE);
    chk(hdr[31:24] == 8'h03, "R3 command", hdr[31:24], 8'h03);
    chk(hdr[23:0] == exp_base, "R3 page address", hdr[23:0], exp_base);
  end
  always @(posedge clk) hi_cnt <= spi_cs_n ? hi_cnt + 1 : 0;

  task automatic do_read(input logic [23:0] a, input string tagname);
    automatic int sc = 0;
    automatic bit miss = !(have_page && cur_page == {a[23:PB], {PB{1'b0}}});
    exp_base = {a[23:PB], {PB{1'b0}}};
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #0.5;
    while (stall) begin @(negedge clk); sc++; end
    @(negedge clk);
    req = 1'b0;
    if (miss)
      chk(sc >= 2 * (32 + 8 * PAGE), {tagname, " R2 miss stall"}, sc, 2 * (32 + 8 * PAGE));
    else
      chk(sc == 0, {tagname, " R1 hit no stall"}, sc, 0);
    chk(rdata == fbyte(a), {tagname, " R1 R2 read data"}, rdata, fbyte(a));
    have_page = 1; cur_page = exp_base;
  endtask

  task automatic do_write(input logic [23:0] a);
    automatic int f0 = fills;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a;
    #0.5;
    chk(!stall, "R7 write no stall", stall, 0);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    repeat (3) @(negedge clk);
    chk(spi_cs_n && fills == f0, "R7 write no spi", fills, f0);
  endtask

  logic [23:0] pool [4] = '{24'h00C000, 24'h020000, 24'hFFFFC0, 24'h5A5A40};

  initial begin
    #(4 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(spi_cs_n && !spi_sck && !stall, "R9 reset outputs", {spi_cs_n, spi_sck, stall}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n && !spi_sck, "R9 after reset", {spi_cs_n, spi_sck}, 2'b10);
    // R6: reset tag names base page but nothing is valid
    do_read(24'h00C005, "R6 first read");
    chk(fills == 1, "R6 first access filled", fills, 1);
    do_read(24'h00C03F, "R1 same page");
    do_read(24'h00C000, "R1 page start");
    do_write(24'h00C010);
    do_read(24'h00C010, "R7 after write");
    // R8: replace then revisit
    do_read(24'h020003, "R8 new page");
    do_read(24'h00C011, "R8 old page again");
    chk(fills == 3, "R8 refetch count", fills, 3);
    do_read(24'hFFFFFF, "R3 top byte");
    for (int i = 0; i < 60; i++) begin
      automatic logic [23:0] a = pool[$urandom % 4] + 24'($urandom % PAGE);
      if ($urandom % 6 == 0) do_write(a);
      else do_read(a, "rand");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule